// File: doc/BRIEF.md
# Selectable-Unit Watchdog Timer

This block is a watchdog whose deadline is set in whole seconds or whole minutes. Host firmware programs it through a small byte-wide register bank, and it counts down from a 16-bit load value on an external one-second tick. If software stops refreshing it and the count runs out, the block can assert a keyboard-controller reset, drop a power-good line, or both. Each of those actions has its own enable bit.

Writing the low byte of the load value is the refresh. That write joins the new low byte with the high byte written earlier, reloads the counter and restarts the minute prescaler. Loading zero disarms the timer. When the count expires, a sticky status bit is set and each enabled action fires as a fixed-width pulse. The counter then rests at zero until it is loaded again. The control register and the four-bit interrupt-select field are only stored and read back.

Top module: `wdog_unit_timer`

## Requirements
- R1: After reset every register reads 0, `kbd_rst_o` is 0 and `pwr_good_o` is 1.
- R2: Register offsets are fixed: 0x71 control, 0x72 configuration, 0x73 load low byte, 0x74 load high byte. Each reads back its last written value on `reg_rdata`. Configuration bit 5 reads the status flag, not the written bit. Any other address reads 0.
- R3: With configuration bit 7 set (seconds), expiry occurs at the clock edge that samples the N-th `tick_1s` pulse after the low-byte write, where N = {high byte, low byte}.
- R4: With configuration bit 7 clear (minutes), expiry occurs on the (60·N)-th tick pulse after the low-byte write.
- R5: Loading a value of 0 disarms the timer, and no number of ticks produces an expiry.
- R6: A low-byte write while counting restarts the full count, including the minute prescaler.
- R7: On expiry with configuration bit 6 set, `kbd_rst_o` goes high for exactly 16 clock cycles. With bit 6 clear it stays low.
- R8: On expiry with configuration bit 4 set, `pwr_good_o` goes low for exactly 16 clock cycles. With bit 4 clear it stays high.
- R9: Expiry sets status bit 5. A configuration write with bit 5 at 1 clears it, and a write with bit 5 at 0 leaves it set.
- R10: After an expiry, further ticks produce no new pulse until the timer is reloaded.
- R11: A high-byte write alone does not change a running count. It takes effect only at the next low-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick_1s | input | 1 | One-cycle pulse once per second |
| kbd_rst_o | output | 1 | Keyboard-reset pulse, active high |
| pwr_good_o | output | 1 | Power-good, driven low on an enabled expiry |

## Verification
A corrupted count or prescaler shows up only at expiry. The reset pulse then appears one or more ticks early or late, or never, so the bench checks the tick just before the deadline as well as the tick that reaches it. A wrong pulse counter shows as a width other than 16 cycles within the next 20 cycles. A stuck status flag shows on the next configuration read. Sweeps over load values 1 to 4 with all four combinations of the two enables, a 256-tick load that uses the high byte, and minute-mode runs across the 60-tick prescaler boundary make each such fault visible within one timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam logic [7:0] ADR_CTRL = 8'h71;
   localparam logic [7:0] ADR_CFG  = 8'h72;
   localparam logic [7:0] ADR_VLO  = 8'h73;
   localparam logic [7:0] ADR_VHI  = 8'h74;

   localparam int CB_SEC = 7;
   localparam int CB_KBD = 6;
   localparam int CB_STS = 5;
   localparam int CB_PG  = 4;

   typedef struct packed {
      logic       sec_mode;
      logic       kbd_en;
      logic       pg_en;
      logic [3:0] irq_sel;
   } wd_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   input  logic             expire,
   output logic [7:0]       rdata,
   output wd_cfg_t          cfg,
   output logic             reload,
   output logic [CNT_W-1:0] reload_val
);
   logic [7:0] ctrl_q, vlo_q, vhi_q;
   wd_cfg_t    cfg_q;
   logic       sts_q;
   logic [15:0] joined;

   wire wr_ctrl = wr && (addr == ADR_CTRL);
   wire wr_cfg  = wr && (addr == ADR_CFG);
   wire wr_vlo  = wr && (addr == ADR_VLO);
   wire wr_vhi  = wr && (addr == ADR_VHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         vlo_q  <= '0;
         vhi_q  <= '0;
         cfg_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata;
         if (wr_vlo)  vlo_q  <= wdata;
         if (wr_vhi)  vhi_q  <= wdata;
         if (wr_cfg)  cfg_q  <= '{sec_mode: wdata[CB_SEC], kbd_en: wdata[CB_KBD],
                                  pg_en: wdata[CB_PG], irq_sel: wdata[3:0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      sts_q <= 1'b0;
      else if (expire)                 sts_q <= 1'b1;
      else if (wr_cfg && wdata[CB_STS]) sts_q <= 1'b0;
   end

   assign joined     = {vhi_q, wdata};
   assign reload     = wr_vlo;
   assign reload_val = joined[CNT_W-1:0];
   assign cfg        = cfg_q;

   always_comb begin
      unique case (addr)
         ADR_CTRL: rdata = ctrl_q;
         ADR_CFG:  rdata = {cfg_q.sec_mode, cfg_q.kbd_en, sts_q, cfg_q.pg_en, cfg_q.irq_sel};
         ADR_VLO:  rdata = vlo_q;
         ADR_VHI:  rdata = vhi_q;
         default:  rdata = 8'h00;
      endcase
   end

   AST_STS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> sts_q); // R9
   AST_STS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !(wr_cfg && wdata[CB_STS])) |=> sts_q); // R9
endmodule

// File: rtl/wdog_tbase.sv
module wdog_tbase #(
   parameter int MIN_DIV = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1s,
   input  logic sec_mode,
   input  logic run,
   input  logic clr,
   output logic unit_tick
);
   generate
      if (MIN_DIV > 1) begin : g_div
         localparam int PW = $clog2(MIN_DIV);
         localparam logic [PW-1:0] LAST = PW'(MIN_DIV - 1);
         logic [PW-1:0] pre_q;
         wire wrap = (pre_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre_q <= '0;
            else if (clr || !run)  pre_q <= '0;
            else if (tick_1s)      pre_q <= wrap ? '0 : pre_q + 1'b1;
         end

         assign unit_tick = tick_1s && (sec_mode || wrap);

         AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= LAST); // R4
      end else begin : g_pass
         assign unit_tick = tick_1s;
      end
   endgenerate
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             unit_tick,
   output logic             expire,
   output logic             running
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (reload)                  cnt_q <= reload_val;
      else if (unit_tick && running)    cnt_q <= cnt_q - ONE;
   end

   assign running = (cnt_q != '0);
   assign expire  = unit_tick && !reload && (cnt_q == ONE);

   AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt_q == $past(reload_val))); // R6
   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !reload) |=> !running); // R5
   AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !running); // R10
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int PULSE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(PULSE_CYC + 1);
   localparam logic [CW-1:0] FULL = CW'(PULSE_CYC);
   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (trig)           left_q <= FULL;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign active = (left_q != '0);

   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> active); // R7
   AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && !active) |=> !active); // R7
endmodule

// File: rtl/wdog_unit_timer.sv
module wdog_unit_timer
   import wdog_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int MIN_DIV   = 60,
   parameter int PULSE_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       tick_1s,
   output logic       kbd_rst_o,
   output logic       pwr_good_o
);
   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         initial $error("CNT_W must lie in 9..16");
      end
      if (MIN_DIV < 1 || PULSE_CYC < 1) begin : g_bad_count
         initial $error("MIN_DIV and PULSE_CYC must be positive");
      end
   endgenerate

   wd_cfg_t          cfg;
   logic             reload, expire, running, unit_tick;
   logic [CNT_W-1:0] reload_val;
   logic             kbd_act, pg_act;

   wdog_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .expire(expire), .rdata(reg_rdata), .cfg(cfg), .reload(reload),
      .reload_val(reload_val));

   wdog_tbase #(.MIN_DIV(MIN_DIV)) u_tbase (
      .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .sec_mode(cfg.sec_mode),
      .run(running), .clr(reload), .unit_tick(unit_tick));

   wdog_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .reload(reload), .reload_val(reload_val),
      .unit_tick(unit_tick), .expire(expire), .running(running));

   wdog_pulse #(.PULSE_CYC(PULSE_CYC)) u_kbd (
      .clk(clk), .rst_n(rst_n), .trig(expire && cfg.kbd_en), .active(kbd_act));

   wdog_pulse #(.PULSE_CYC(PULSE_CYC)) u_pg (
      .clk(clk), .rst_n(rst_n), .trig(expire && cfg.pg_en), .active(pg_act));

   assign kbd_rst_o  = kbd_act;
   assign pwr_good_o = !pg_act;

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !kbd_rst_o && !reload) |=> !kbd_rst_o); // R10
endmodule

// File: tb/sim_wdog_unit_timer.sv
`timescale 1ns/1ps
module sim_wdog_unit_timer;
   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, tick_1s = 1'b0;
   logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic kbd_rst_o, pwr_good_o;
   int   n_chk = 0, n_bad = 0;
   int   kb_ev = 0, pg_ev = 0;
   logic kb_q = 1'b0, pg_q = 1'b1;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   wdog_unit_timer u0 (.*);

   always @(posedge clk) begin
      #1;
      if (kbd_rst_o && !kb_q) kb_ev++;
      if (!pwr_good_o && pg_q) pg_ev++;
      kb_q = kbd_rst_o;
      pg_q = pwr_good_o;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_1s = 1'b1;
         @(negedge clk); tick_1s = 1'b0;
      end
   endtask

   task automatic load(input int v);
      wr(8'h74, 8'((v >> 8) & 255));
      wr(8'h73, 8'(v & 255));
   endtask

   task automatic clr_ev;
      @(negedge clk); kb_ev = 0; pg_ev = 0;
   endtask

   // measure the high cycles of kbd and low cycles of power-good over 20 cycles
   task automatic widths(output int kw, output int pw);
      kw = 0; pw = 0;
      for (int i = 0; i < 20; i++) begin
         if (kbd_rst_o) kw++;
         if (!pwr_good_o) pw++;
         @(negedge clk);
      end
   endtask

   initial begin
      logic [7:0] d;
      int kw, pw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 kbd", kbd_rst_o, 0);
      chk("R1 pwr_good", pwr_good_o, 1);
      for (int a = 8'h71; a <= 8'h74; a++) begin
         rd(8'(a), d); chk("R1 reg zero", d, 0);
      end
      // R2 readback
      wr(8'h71, 8'hA5); rd(8'h71, d); chk("R2 ctrl", d, 8'hA5);
      wr(8'h72, 8'h9F); rd(8'h72, d); chk("R2 cfg", d, 8'h9F);
      wr(8'h72, 8'h3F); rd(8'h72, d); chk("R2 cfg status bit", d, 8'h1F);
      wr(8'h74, 8'h12); rd(8'h74, d); chk("R2 hi", d, 8'h12);
      wr(8'h73, 8'h34); rd(8'h73, d); chk("R2 lo", d, 8'h34);
      rd(8'h75, d); chk("R2 unmapped", d, 0);
      load(0);
      // R3 R7 R8 R9 R10 sweep in seconds mode
      for (int en = 0; en < 4; en++) begin
         for (int n = 1; n <= 4; n++) begin
            logic [7:0] c;
            c = 8'(8'h80 | ((en & 1) << 6) | ((en >> 1) << 4));
            wr(8'h72, c);
            load(n);
            clr_ev();
            ticks(n - 1);
            chk("R3 no early expiry", kb_ev + pg_ev, 0);
            ticks(1);
            chk("R7 kbd at deadline", kbd_rst_o, en & 1);
            chk("R8 pwr_good at deadline", pwr_good_o, 1 - (en >> 1));
            widths(kw, pw);
            chk("R7 kbd width", kw, (en & 1) * 16);
            chk("R8 pg width", pw, (en >> 1) * 16);
            rd(8'h72, d); chk("R9 status set", d[5], 1);
            ticks(5);
            chk("R10 no repeat", kb_ev + pg_ev, (en & 1) + (en >> 1));
            wr(8'h72, c);
            rd(8'h72, d); chk("R9 write0 keeps", d[5], 1);
            wr(8'h72, c | 8'h20);
            rd(8'h72, d); chk("R9 w1c clears", d, c);
         end
      end
      // R3 high byte: 256 ticks
      wr(8'h72, 8'hC0); load(256); clr_ev();
      ticks(255); chk("R3 hi no early", kb_ev, 0);
      ticks(1);   chk("R3 hi deadline", kbd_rst_o, 1);
      repeat (20) @(negedge clk);
      // R11 high byte write alone
      load(3); clr_ev();
      ticks(1); wr(8'h74, 8'h01);
      ticks(1); chk("R11 no early", kb_ev, 0);
      ticks(1); chk("R11 expiry at 3", kbd_rst_o, 1);
      repeat (20) @(negedge clk);
      // R4 minute mode
      for (int n = 1; n <= 2; n++) begin
         wr(8'h72, 8'h50); load(n); clr_ev();
         ticks(60 * n - 1);
         chk("R4 no early", pg_ev, 0);
         ticks(1);
         chk("R4 minute deadline", pwr_good_o, 0);
         repeat (20) @(negedge clk);
      end
      // R6 keepalive in minute mode clears prescaler
      wr(8'h72, 8'h40); load(1); clr_ev();
      ticks(59); load(1); ticks(59);
      chk("R6 keepalive holds off", kb_ev, 0);
      ticks(1);
      chk("R6 expiry after refresh", kbd_rst_o, 1);
      repeat (20) @(negedge clk);
      // R6 seconds mode refresh
      wr(8'h72, 8'hC0); load(3); clr_ev();
      ticks(2); load(3); ticks(2);
      chk("R6 sec refresh holds off", kb_ev, 0);
      ticks(1); chk("R6 sec expiry", kbd_rst_o, 1);
      repeat (20) @(negedge clk);
      // R5 zero stops
      wr(8'h72, 8'hD0); load(5); clr_ev();
      ticks(2); load(0); ticks(100);
      chk("R5 zero stops", kb_ev + pg_ev, 0);
      chk("R5 pwr_good idle", pwr_good_o, 1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule